// File: doc/BRIEF.md
# Hetero-Associative Memory Node

This block is one storage node of a bidirectional hetero-associative memory. It holds a small table indexed by a symbol of the neighbouring variable. Each entry holds a symbol of the node's own variable. A symbol value of zero means that no data is present. Zero is therefore never written as content, and a zero input never addresses a valid entry.

In learning, the node is shown a neighbour symbol and an own symbol together. It raises a conflict flag when the addressed entry already holds a different valid symbol. The peer decision logic sits outside the node and returns an update permit. The pair is written on the next clock edge when both learning and the permit are asserted, and it replaces any earlier content of that entry.

Recall works in both directions and is purely combinational:
- A presented neighbour symbol reads its entry, giving a value and a valid flag.
- A presented own-variable symbol is compared against every entry at once. The result is a vector with one bit per entry, marking each entry that holds the symbol.

Top module: `assoc_node`

## Requirements
- R1: While `rst_n` is low on a rising edge, every entry is cleared to 0. Right after reset, `recall_valid` is 0 for every neighbour symbol, and `search_hits` is all zero for every query.
- R2: When `learn_en` and `upd_permit` are both 1 on a rising edge, and both `nbr_sym` and `own_sym` are nonzero, entry `nbr_sym` takes the value `own_sym`.
- R3: When `learn_en` or `upd_permit` is 0 on an edge, no entry changes.
- R4: A zero `own_sym` or a zero `nbr_sym` never causes a write, so entry 0 stays 0 and a stored value is never 0.
- R5: `conflict` is 1 exactly when all of these hold:
  - `learn_en` is 1;
  - `nbr_sym` and `own_sym` are both nonzero;
  - entry `nbr_sym` holds a nonzero value that differs from `own_sym`.
- R6: `recall_valid` is 1 exactly when `nbr_sym` is nonzero and entry `nbr_sym` is nonzero. `recall_sym` is then that entry, and otherwise 0. Both outputs follow the inputs and the table without a clock edge.
- R7: Bit i of `search_hits` is 1 exactly when `search_sym` is nonzero and entry i equals `search_sym`. Several bits may be set at once. The vector follows a write from the next edge onward.
- R8: A permitted write while `conflict` is 1 replaces the old content with `own_sym`.
- R9: `search_any` is 1 exactly when at least one bit of `search_hits` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears the table |
| learn_en | input | 1 | Learning mode; enables conflict detection and writes |
| upd_permit | input | 1 | Update permit from the peer decision logic |
| nbr_sym | input | SYM_W | Neighbour-variable symbol: write address and recall key |
| own_sym | input | SYM_W | Own-variable symbol to be learned |
| search_sym | input | SYM_W | Own-variable symbol searched across all entries |
| conflict | output | 1 | Addressed entry holds a different valid symbol |
| recall_sym | output | SYM_W | Symbol read for `nbr_sym`, 0 when not valid |
| recall_valid | output | 1 | `recall_sym` carries a stored symbol |
| search_hits | output | 2**SYM_W | One bit per entry holding `search_sym` |
| search_any | output | 1 | At least one entry holds `search_sym` |

## Verification
The bench builds the node with its default 4-bit symbols, which gives a 16-entry table. Every address and every symbol value is therefore reachable.

The random traffic draws neighbour and own symbols from a narrow range. This makes entries collide often, so conflicts, overwrites and multi-bit search results occur many times. The zero symbol also appears regularly, so the rule that it is never stored is exercised from both the address side and the data side.

// File: rtl/assoc_node_pkg.sv
// Package: assoc_node_pkg
// Shared defaults for the associative memory node.
// Assumes symbols are unsigned and that value 0 is the "absent" marker.
package assoc_node_pkg;
    localparam int unsigned NODE_SYM_W = 4;
    localparam logic [31:0] SYM_ABSENT = 32'd0;
endpackage

// File: rtl/assoc_node_table.sv
// Module: assoc_node_table
// Storage of the node: one entry per neighbour symbol, written
// synchronously and read combinationally.
// Assumes the write enable already excludes zero address and zero data.
module assoc_node_table #(
    parameter int unsigned SYM_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SYM_W-1:0]                  wr_addr,
    input  logic [SYM_W-1:0]                  wr_data,
    input  logic [SYM_W-1:0]                  rd_addr,
    output logic [SYM_W-1:0]                  rd_data,
    output logic [(1<<SYM_W)-1:0][SYM_W-1:0]  mem_o
);
    localparam int unsigned DEPTH = 1 << SYM_W;

    logic [DEPTH-1:0][SYM_W-1:0] mem_q;

    // Clear on reset, otherwise store the permitted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read port for recall.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

    assign mem_o = mem_q;

    // A reset edge leaves the whole table empty.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_q == '0));

    // A permitted write lands at its address.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

    // Without a write enable the table holds.
    assert_no_write_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));

    // The gate upstream never lets a zero address or zero datum through.
    assert_zero_not_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data != '0) && (wr_addr != '0)));
endmodule

// File: rtl/assoc_node_learn.sv
// Module: assoc_node_learn
// Learning control: detects a conflict against the addressed entry
// and gates the write with the external update permit.
// Assumes `stored` is the combinational read of entry `nbr_sym`.
module assoc_node_learn #(
    parameter int unsigned SYM_W = 4
) (
    input  logic             learn_en,
    input  logic             upd_permit,
    input  logic [SYM_W-1:0] nbr_sym,
    input  logic [SYM_W-1:0] own_sym,
    input  logic [SYM_W-1:0] stored,
    output logic             conflict,
    output logic             wr_en
);
    logic both_present;

    // Both symbols must carry data for learning to act.
    always_comb begin
        both_present = (nbr_sym != '0) && (own_sym != '0);
    end

    // A conflict is a valid entry that disagrees with the new symbol.
    always_comb begin
        conflict = learn_en && both_present && (stored != '0) && (stored != own_sym);
    end

    // A write needs learning, the permit and real data.
    always_comb begin
        wr_en = learn_en && upd_permit && both_present;
    end
endmodule

// File: rtl/assoc_node_recall.sv
// Module: assoc_node_recall
// Forward recall: qualifies the entry read for a neighbour symbol.
// Assumes an entry value of 0 means empty.
module assoc_node_recall #(
    parameter int unsigned SYM_W = 4
) (
    input  logic [SYM_W-1:0] nbr_sym,
    input  logic [SYM_W-1:0] stored,
    output logic [SYM_W-1:0] recall_sym,
    output logic             recall_valid
);
    // Valid only for a present key addressing a filled entry.
    always_comb begin
        recall_valid = (nbr_sym != '0) && (stored != '0);
        recall_sym   = recall_valid ? stored : '0;
    end
endmodule

// File: rtl/assoc_node_search.sv
// Module: assoc_node_search
// Reverse recall: compares every entry against a key in parallel,
// one XNOR per stored bit, reducing each entry to one hit bit.
// Assumes a zero key means no query and must produce no hits.
module assoc_node_search #(
    parameter int unsigned SYM_W = 4
) (
    input  logic [(1<<SYM_W)-1:0][SYM_W-1:0] mem_i,
    input  logic [SYM_W-1:0]                 key,
    output logic [(1<<SYM_W)-1:0]            hits,
    output logic                             any_hit
);
    localparam int unsigned DEPTH = 1 << SYM_W;

    logic key_present;

    // A query exists only for a nonzero key.
    always_comb begin
        key_present = (key != '0);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [SYM_W-1:0] bit_eq;
        // Bitwise equality of entry i against the key.
        always_comb begin
            bit_eq  = ~(mem_i[i] ^ key);
            hits[i] = key_present && (&bit_eq);
        end
    end

    // Summary of all per-entry hits.
    always_comb begin
        any_hit = |hits;
    end
endmodule

// File: rtl/assoc_node.sv
// Module: assoc_node
// One node of a bidirectional hetero-associative memory. The neighbour
// symbol addresses a table of own-variable symbols; learning writes on
// permit, recall reads by address or by content search.
// Assumes the peer vote arrives already resolved on upd_permit.
module assoc_node #(
    parameter int unsigned SYM_W = assoc_node_pkg::NODE_SYM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    learn_en,
    input  logic                    upd_permit,
    input  logic [SYM_W-1:0]        nbr_sym,
    input  logic [SYM_W-1:0]        own_sym,
    input  logic [SYM_W-1:0]        search_sym,
    output logic                    conflict,
    output logic [SYM_W-1:0]        recall_sym,
    output logic                    recall_valid,
    output logic [(1<<SYM_W)-1:0]   search_hits,
    output logic                    search_any
);
    localparam int unsigned DEPTH = 1 << SYM_W;

    logic                        wr_en;
    logic [SYM_W-1:0]            stored;
    logic [DEPTH-1:0][SYM_W-1:0] mem_view;

    assoc_node_table #(.SYM_W(SYM_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (nbr_sym),
        .wr_data (own_sym),
        .rd_addr (nbr_sym),
        .rd_data (stored),
        .mem_o   (mem_view)
    );

    assoc_node_learn #(.SYM_W(SYM_W)) learn_i (
        .learn_en   (learn_en),
        .upd_permit (upd_permit),
        .nbr_sym    (nbr_sym),
        .own_sym    (own_sym),
        .stored     (stored),
        .conflict   (conflict),
        .wr_en      (wr_en)
    );

    assoc_node_recall #(.SYM_W(SYM_W)) recall_i (
        .nbr_sym      (nbr_sym),
        .stored       (stored),
        .recall_sym   (recall_sym),
        .recall_valid (recall_valid)
    );

    assoc_node_search #(.SYM_W(SYM_W)) search_i (
        .mem_i   (mem_view),
        .key     (search_sym),
        .hits    (search_hits),
        .any_hit (search_any)
    );

    // A permitted write over a conflicting entry replaces it.
    assert_conflict_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && upd_permit) |=> (mem_view[$past(nbr_sym)] == $past(own_sym)));

    // A freshly written symbol is found by an unchanged search key.
    assert_search_sees_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (search_sym == own_sym)) |=>
            (!$stable(search_sym) || search_hits[$past(nbr_sym)]));
endmodule

// File: tb/assoc_node_tb.sv
// Bench: fixed-seed random traffic plus directed corner cases, each
// step compared against a behavioural table model kept in the bench.
module assoc_node_tb_top;
    localparam int SYM_W = 4;
    localparam int DEPTH = 1 << SYM_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             learn_en = 1'b0;
    logic             upd_permit = 1'b0;
    logic [SYM_W-1:0] nbr_sym = '0;
    logic [SYM_W-1:0] own_sym = '0;
    logic [SYM_W-1:0] search_sym = '0;
    logic             conflict;
    logic [SYM_W-1:0] recall_sym;
    logic             recall_valid;
    logic [DEPTH-1:0] search_hits;
    logic             search_any;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [SYM_W-1:0] model [DEPTH];

    always #2 clk = ~clk;

    assoc_node #(.SYM_W(SYM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .upd_permit(upd_permit),
        .nbr_sym(nbr_sym), .own_sym(own_sym), .search_sym(search_sym),
        .conflict(conflict), .recall_sym(recall_sym), .recall_valid(recall_valid),
        .search_hits(search_hits), .search_any(search_any)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DEPTH-1:0] exp_hits(input logic [SYM_W-1:0] q);
        logic [DEPTH-1:0] h = '0;
        for (int i = 0; i < DEPTH; i++) h[i] = (q != 0) && (model[i] == q);
        return h;
    endfunction

    // Drive one step, check combinational outputs, then commit an edge.
    task automatic step(input bit l, input bit p, input int n, input int o, input int s);
        logic [SYM_W-1:0] st, ex_rs;
        bit ex_cf, ex_rv;
        logic [DEPTH-1:0] ex_h;
        @(negedge clk);
        learn_en = l; upd_permit = p;
        nbr_sym = SYM_W'(n); own_sym = SYM_W'(o); search_sym = SYM_W'(s);
        #1;
        st    = model[nbr_sym];
        ex_cf = l && (nbr_sym != 0) && (own_sym != 0) && (st != 0) && (st != own_sym);
        ex_rv = (nbr_sym != 0) && (st != 0);
        ex_rs = ex_rv ? st : '0;
        ex_h  = exp_hits(search_sym);
        chk(conflict == ex_cf, "R5 conflict", int'(conflict), int'(ex_cf));
        chk(recall_valid == ex_rv, "R6 recall_valid", int'(recall_valid), int'(ex_rv));
        chk(recall_sym == ex_rs, "R6 recall_sym", int'(recall_sym), int'(ex_rs));
        chk(search_hits == ex_h, "R7 search_hits", int'(search_hits), int'(ex_h));
        chk(search_any == (ex_h != 0), "R9 search_any", int'(search_any), int'(ex_h != 0));
        @(posedge clk);
        if (l && p && (nbr_sym != 0) && (own_sym != 0)) model[nbr_sym] = own_sym;
    endtask

    // Peek at one entry through the recall port without writing.
    task automatic peek(input int n, input int exp, input string tag);
        @(negedge clk);
        learn_en = 1'b0; upd_permit = 1'b0; nbr_sym = SYM_W'(n); search_sym = '0;
        #1;
        chk(recall_sym == SYM_W'(exp), tag, int'(recall_sym), exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset, by address and by content.
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            nbr_sym = SYM_W'(a); search_sym = SYM_W'(a);
            #1;
            chk(recall_valid == 1'b0, "R1 recall_valid after reset", int'(recall_valid), 0);
            chk(search_hits == '0, "R1 search_hits after reset", int'(search_hits), 0);
        end
        // R2/R6: write then read back.
        step(1, 1, 3, 5, 5);
        peek(3, 5, "R2 written entry");
        // R3: learning without permit, permit without learning.
        step(1, 0, 4, 9, 0);
        step(0, 1, 4, 9, 0);
        peek(4, 0, "R3 no write without both enables");
        // R4: zero symbols are never stored.
        step(1, 1, 8, 0, 0);
        peek(8, 0, "R4 zero own symbol ignored");
        step(1, 1, 0, 6, 6);
        peek(0, 0, "R4 zero address ignored");
        step(0, 0, 0, 0, 6);
        // R5/R8: conflict and overwrite.
        step(1, 0, 3, 7, 0);
        step(1, 0, 3, 5, 0);
        step(1, 1, 3, 7, 7);
        peek(3, 7, "R8 conflict overwrite");
        // R7: multi-hit search.
        step(1, 1, 6, 7, 7);
        step(0, 0, 0, 0, 7);
        chk(search_hits == 16'h0048, "R7 two hits", int'(search_hits), 16'h0048);
        step(0, 0, 0, 0, 0);
        // Random traffic with narrow symbol ranges to force collisions.
        for (int k = 0; k < 600; k++) begin
            step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 5)),
                 int'($urandom_range(0, 5)));
        end
        // R1: reset in the middle of traffic empties the table again.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 3, 0, 7);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule